// File: doc/BRIEF.md
# Lockable Translation Buffer for a Device MMU

This block is a small, fully associative address-translation cache for the device side of a memory management unit. Each slot holds a virtual tag, a page-size code, a valid bit and a preserved bit, together with a physical base and a set of attribute bits. The page sizes are 4 KB, 64 KB, 1 MB and 16 MB. A lookup port takes a device address and, one cycle later, returns a hit with the translated physical address and attributes, or a one-cycle miss.

A lock register decides where loads go. It holds a base index and a victim index. Slots below the base are protected from replacement. Each load writes the slot the victim index points to, and the victim then advances round-robin through the unprotected slots. Software reads a slot by pointing the victim index at it and observing the read-back outputs. It invalidates by address, which removes every entry whose page covers that address, or flushes the whole buffer, which also clears the lock register.

Top module: `iotlb_lockable`

## Requirements
- R1: After reset every slot is invalid, lock base and victim are 0, `ld_err` is 0, and the lookup outputs are 0.
- R2: The size code picks the page size: 0 = 4 KB (12 offset bits), 1 = 64 KB (16), 2 = 1 MB (20), 3 = 16 MB (24). A valid entry matches when the address bits above its offset width equal its tag bits above that width. The translated address is the entry's physical bits above the offset width joined with the lookup address's offset bits.
- R3: Lookup results are registered. In the cycle after `lk_valid`, either `lk_hit` or `lk_miss` is 1. If several entries match, the lowest slot index supplies the result. On a miss, and when no lookup was requested, `lk_pa` and `lk_attr` are 0. Without `lk_valid`, both `lk_hit` and `lk_miss` are 0.
- R4: An accepted load writes the slot at the victim index. The victim then becomes victim+1. When victim+1 equals the entry count, the victim wraps to the base, or to 0 if the base equals the entry count.
- R5: An accepted load with `ld_prsv` set moves the base to the loaded slot index plus one.
- R6: A load is rejected when the base equals the entry count, or when the victim is below the base. A rejected load leaves every slot and the lock register unchanged, and `ld_err` is 1 for exactly the following cycle.
- R7: The read-back outputs always show the contents of the slot the victim index points to.
- R8: A flush by address invalidates every valid entry, preserved or not, whose page contains the address (start <= addr < start + page bytes). Other entries and the lock register are unchanged.
- R9: A global flush invalidates every slot and sets base and victim to 0.
- R10: A lock-register write takes effect on the next cycle. A base value above the entry count is stored as the entry count, and a victim value above the last index is stored as the last index.
- R11: Only one operation takes effect per cycle, in this priority: global flush, then flush by address, then load, then lock write. Operations of lower priority in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_we | input | 1 | Write the lock register |
| lock_base_wr | input | BW | Base index to write |
| lock_vict_wr | input | VW | Victim index to write |
| lock_base | output | BW | Current base index |
| lock_vict | output | VW | Current victim index |
| ld_stb | input | 1 | Load the staged entry at the victim slot |
| ld_tag | input | VA_W | Virtual tag of the staged entry |
| ld_size | input | 2 | Page-size code of the staged entry |
| ld_prsv | input | 1 | Staged entry is preserved |
| ld_pa | input | PA_W | Physical base of the staged entry |
| ld_attr | input | ATTR_W | Attributes of the staged entry |
| ld_err | output | 1 | Previous cycle's load was rejected |
| rd_valid | output | 1 | Valid bit of the slot at the victim index |
| rd_prsv | output | 1 | Preserved bit of that slot |
| rd_tag | output | VA_W | Tag of that slot |
| rd_size | output | 2 | Size code of that slot |
| rd_pa | output | PA_W | Physical base of that slot |
| rd_attr | output | ATTR_W | Attributes of that slot |
| flush_addr_stb | input | 1 | Invalidate entries covering `flush_addr` |
| flush_addr | input | VA_W | Address for flush by address |
| flush_all_stb | input | 1 | Invalidate all entries and clear the lock register |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | VA_W | Device address to translate |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_miss | output | 1 | Lookup miss, one cycle after the request |
| lk_pa | output | PA_W | Translated physical address |
| lk_attr | output | ATTR_W | Attributes of the hitting entry |

## Verification
The hardest state to reach is a wrap of the victim pointer while a preserved region exists, combined with overlapping pages of different sizes. In that state the replacement order, the lowest-index rule and range-based invalidation all interact. The stimulus loads a preserved 4 KB page and a later 16 MB page that covers it, then fills the remaining slots until the victim wraps back to the base. It overwrites a slot after the wrap, and then flushes one address inside both overlapping pages. Rejected loads are reached by writing a victim below the base, and by writing an out-of-range base that clamps to the full state.

// File: rtl/iotlb_pkg.sv
`timescale 1ns/1ps
package iotlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  // Number of address bits inside a page of the given size code.
  function automatic int unsigned off_bits(logic [1:0] sz);
    return 32'd12 + 32'd4 * 32'(sz);
  endfunction
endpackage

// File: rtl/iotlb_slot.sv
`timescale 1ns/1ps
module iotlb_slot #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VA_W-1:0]   wr_tag,
  input  logic [1:0]        wr_size,
  input  logic              wr_prsv,
  input  logic [PA_W-1:0]   wr_pa,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              kill,
  input  logic [VA_W-1:0]   lk_addr,
  input  logic [VA_W-1:0]   fl_addr,
  output logic              valid,
  output logic [VA_W-1:0]   tag,
  output logic [1:0]        size,
  output logic              prsv,
  output logic [PA_W-1:0]   pa,
  output logic [ATTR_W-1:0] attr,
  output logic              lk_match,
  output logic              fl_match
);
  import iotlb_pkg::*;

  function automatic logic covers(logic [VA_W-1:0] a, logic [VA_W-1:0] t, logic [1:0] sz);
    logic [VA_W-1:0] m;
    m = {VA_W{1'b1}} << off_bits(sz);
    return ((a ^ t) & m) == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      size  <= '0;
      prsv  <= 1'b0;
      pa    <= '0;
      attr  <= '0;
    end else if (kill) begin
      valid <= 1'b0;
    end else if (wr_en) begin
      valid <= 1'b1;
      tag   <= wr_tag;
      size  <= wr_size;
      prsv  <= wr_prsv;
      pa    <= wr_pa;
      attr  <= wr_attr;
    end
  end

  assign lk_match = valid && covers(lk_addr, tag, size);
  assign fl_match = valid && covers(fl_addr, tag, size);

  // R8
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid);
  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kill) |=> (valid && tag == $past(wr_tag) && pa == $past(wr_pa)));
endmodule

// File: rtl/iotlb_lockreg.sv
`timescale 1ns/1ps
module iotlb_lockreg #(
  parameter int N  = 8,
  parameter int BW = $clog2(N + 1),
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [BW-1:0] base_in,
  input  logic [VW-1:0] vict_in,
  input  logic          ld_req,
  input  logic          ld_prsv,
  output logic [BW-1:0] base,
  output logic [VW-1:0] vict,
  output logic          ld_ok,
  output logic          ld_rej
);
  localparam logic [BW-1:0] FULL  = BW'(N);
  localparam logic [VW-1:0] LASTV = VW'(N - 1);

  logic [BW-1:0] nb, inc, vict_w;
  logic [VW-1:0] nv;

  assign vict_w = BW'(vict);
  assign ld_ok  = ld_req && (base < FULL) && (vict_w >= base);
  assign ld_rej = ld_req && !ld_ok;
  assign inc    = vict_w + BW'(1);

  always_comb begin
    nb = base;
    nv = vict;
    if (clr) begin
      nb = '0;
      nv = '0;
    end else if (ld_ok) begin
      nb = ld_prsv ? inc : base;
      if (inc == FULL) nv = (nb == FULL) ? '0 : VW'(nb);
      else             nv = VW'(inc);
    end else if (wr_en && !ld_req) begin
      nb = (base_in > FULL) ? FULL : base_in;
      nv = (vict_in > LASTV) ? LASTV : vict_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      vict <= '0;
    end else begin
      base <= nb;
      vict <= nv;
    end
  end

  // R10
  base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base <= FULL);
  // R9
  clear_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (base == '0 && vict == '0));
  // R4
  vict_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ok && !clr && !ld_prsv && vict != LASTV) |=> vict == $past(vict) + VW'(1));
  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rej && !clr) |=> ($stable(base) && $stable(vict)));
endmodule

// File: rtl/iotlb_lookup.sv
`timescale 1ns/1ps
module iotlb_lookup #(
  parameter int N      = 8,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ATTR_W = 4,
  parameter int VW     = $clog2(N)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic [VA_W-1:0]             lk_addr,
  input  logic [N-1:0]                match,
  input  logic [N-1:0][PA_W-1:0]      s_pa,
  input  logic [N-1:0][ATTR_W-1:0]    s_attr,
  input  logic [N-1:0][1:0]           s_size,
  output logic                        hit,
  output logic                        miss,
  output logic [PA_W-1:0]             pa,
  output logic [ATTR_W-1:0]           attr
);
  import iotlb_pkg::*;

  function automatic logic [PA_W-1:0] xlate(logic [PA_W-1:0] base, logic [VA_W-1:0] a,
                                            logic [1:0] sz);
    logic [PA_W-1:0] m;
    m = {PA_W{1'b1}} << off_bits(sz);
    return (base & m) | (PA_W'(a) & ~m);
  endfunction

  logic          any;
  logic [VW-1:0] sel;

  // lowest index wins: scan downward so the last assignment is the smallest index
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        sel = VW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lk_valid) begin
      hit  <= 1'b0;
      miss <= 1'b0;
      pa   <= '0;
      attr <= '0;
    end else begin
      hit  <= any;
      miss <= !any;
      pa   <= any ? xlate(s_pa[sel], lk_addr, s_size[sel]) : '0;
      attr <= any ? s_attr[sel] : '0;
    end
  end

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss}));
  // R3
  answer_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> $past(lk_valid));
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (pa == '0 && attr == '0));
endmodule

// File: rtl/iotlb_lockable.sv
`timescale 1ns/1ps
module iotlb_lockable #(
  parameter int N      = 8,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ATTR_W = 4,
  parameter int BW     = $clog2(N + 1),
  parameter int VW     = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_we,
  input  logic [BW-1:0]     lock_base_wr,
  input  logic [VW-1:0]     lock_vict_wr,
  output logic [BW-1:0]     lock_base,
  output logic [VW-1:0]     lock_vict,
  input  logic              ld_stb,
  input  logic [VA_W-1:0]   ld_tag,
  input  logic [1:0]        ld_size,
  input  logic              ld_prsv,
  input  logic [PA_W-1:0]   ld_pa,
  input  logic [ATTR_W-1:0] ld_attr,
  output logic              ld_err,
  output logic              rd_valid,
  output logic              rd_prsv,
  output logic [VA_W-1:0]   rd_tag,
  output logic [1:0]        rd_size,
  output logic [PA_W-1:0]   rd_pa,
  output logic [ATTR_W-1:0] rd_attr,
  input  logic              flush_addr_stb,
  input  logic [VA_W-1:0]   flush_addr,
  input  logic              flush_all_stb,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_addr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr
);
  // one operation per cycle, highest priority first
  logic do_fa, do_fl, do_ld, ld_ok, ld_rej;
  assign do_fa = flush_all_stb;
  assign do_fl = flush_addr_stb && !do_fa;
  assign do_ld = ld_stb && !do_fa && !do_fl;

  logic [N-1:0]              s_vld, s_prs, lk_m, fl_m;
  logic [N-1:0][VA_W-1:0]    s_tag;
  logic [N-1:0][1:0]         s_size;
  logic [N-1:0][PA_W-1:0]    s_pa;
  logic [N-1:0][ATTR_W-1:0]  s_attr;
  logic [N-1:0]              slot_kill;

  iotlb_lockreg #(.N(N), .BW(BW), .VW(VW)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(do_fa),
    .wr_en(lock_we && !do_fa && !do_fl), .base_in(lock_base_wr), .vict_in(lock_vict_wr),
    .ld_req(do_ld), .ld_prsv(ld_prsv),
    .base(lock_base), .vict(lock_vict), .ld_ok(ld_ok), .ld_rej(ld_rej)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot_kill[g] = do_fa || (do_fl && fl_m[g]);
    iotlb_slot #(.VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ld_ok && lock_vict == VW'(g)),
      .wr_tag(ld_tag), .wr_size(ld_size), .wr_prsv(ld_prsv), .wr_pa(ld_pa), .wr_attr(ld_attr),
      .kill(slot_kill[g]), .lk_addr(lk_addr), .fl_addr(flush_addr),
      .valid(s_vld[g]), .tag(s_tag[g]), .size(s_size[g]), .prsv(s_prs[g]),
      .pa(s_pa[g]), .attr(s_attr[g]), .lk_match(lk_m[g]), .fl_match(fl_m[g])
    );
  end

  iotlb_lookup #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W), .VW(VW)) u_look (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr), .match(lk_m),
    .s_pa(s_pa), .s_attr(s_attr), .s_size(s_size),
    .hit(lk_hit), .miss(lk_miss), .pa(lk_pa), .attr(lk_attr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ld_err <= 1'b0;
    else        ld_err <= ld_rej;
  end

  assign rd_valid = s_vld[lock_vict];
  assign rd_prsv  = s_prs[lock_vict];
  assign rd_tag   = s_tag[lock_vict];
  assign rd_size  = s_size[lock_vict];
  assign rd_pa    = s_pa[lock_vict];
  assign rd_attr  = s_attr[lock_vict];

  // R6
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> ($past(ld_stb) && !$past(flush_all_stb) && !$past(flush_addr_stb)));
  // R9
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_stb |=> (s_vld == '0));
  // R11
  flush_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_addr_stb && !flush_all_stb) |=> $stable(lock_vict) && $stable(lock_base));
endmodule

// File: tb/sim_iotlb_lockable.sv
`timescale 1ns/1ps
module sim_iotlb_lockable;
  localparam int N = 8;
  localparam int BW = $clog2(N + 1);
  localparam int VW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          lock_we = 0, ld_stb = 0, ld_prsv = 0, flush_addr_stb = 0, flush_all_stb = 0, lk_valid = 0;
  logic [BW-1:0] lock_base_wr = 0;
  logic [VW-1:0] lock_vict_wr = 0;
  logic [31:0]   ld_tag = 0, ld_pa = 0, flush_addr = 0, lk_addr = 0;
  logic [1:0]    ld_size = 0;
  logic [3:0]    ld_attr = 0;
  logic [BW-1:0] lock_base;
  logic [VW-1:0] lock_vict;
  logic          ld_err, rd_valid, rd_prsv, lk_hit, lk_miss;
  logic [31:0]   rd_tag, rd_pa, lk_pa;
  logic [1:0]    rd_size;
  logic [3:0]    rd_attr, lk_attr;

  iotlb_lockable u0 (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_base_wr(lock_base_wr),
    .lock_vict_wr(lock_vict_wr), .lock_base(lock_base), .lock_vict(lock_vict),
    .ld_stb(ld_stb), .ld_tag(ld_tag), .ld_size(ld_size), .ld_prsv(ld_prsv), .ld_pa(ld_pa),
    .ld_attr(ld_attr), .ld_err(ld_err), .rd_valid(rd_valid), .rd_prsv(rd_prsv),
    .rd_tag(rd_tag), .rd_size(rd_size), .rd_pa(rd_pa), .rd_attr(rd_attr),
    .flush_addr_stb(flush_addr_stb), .flush_addr(flush_addr), .flush_all_stb(flush_all_stb),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pa(lk_pa), .lk_attr(lk_attr)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_v[N], m_p[N];
  logic [31:0] m_t[N], m_a[N];
  int          m_s[N];
  logic [3:0]  m_at[N];
  int          m_base = 0, m_vict = 0;
  bit          m_hit = 0, m_miss = 0, m_err = 0;
  logic [31:0] m_lpa = 0;
  logic [3:0]  m_lat = 0;

  function automatic logic [31:0] pmask(int s);
    return 32'hFFFF_FFFF << (12 + 4 * s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_p[i] = 0; m_t[i] = 0; m_a[i] = 0; m_s[i] = 0; m_at[i] = 0; end
      m_base = 0; m_vict = 0; m_hit = 0; m_miss = 0; m_err = 0; m_lpa = 0; m_lat = 0;
    end else begin
      int w;
      m_hit = 0; m_miss = 0; m_lpa = 0; m_lat = 0; m_err = 0;
      if (lk_valid) begin
        w = -1;
        for (int i = 0; i < N; i++)
          if (w < 0 && m_v[i] && ((lk_addr & pmask(m_s[i])) == (m_t[i] & pmask(m_s[i])))) w = i;
        if (w >= 0) begin
          m_hit = 1;
          m_lpa = (m_a[w] & pmask(m_s[w])) | (lk_addr & ~pmask(m_s[w]));
          m_lat = m_at[w];
        end else m_miss = 1;
      end
      if (flush_all_stb) begin
        foreach (m_v[i]) m_v[i] = 0;
        m_base = 0; m_vict = 0;
      end else if (flush_addr_stb) begin
        for (int i = 0; i < N; i++)
          if (m_v[i] && flush_addr >= (m_t[i] & pmask(m_s[i])) &&
              64'(flush_addr) < 64'(m_t[i] & pmask(m_s[i])) + (64'd1 << (12 + 4 * m_s[i])))
            m_v[i] = 0;
      end else if (ld_stb) begin
        if (m_base == N || m_vict < m_base) m_err = 1;
        else begin
          m_v[m_vict] = 1; m_p[m_vict] = ld_prsv; m_t[m_vict] = ld_tag;
          m_s[m_vict] = int'(ld_size); m_a[m_vict] = ld_pa; m_at[m_vict] = ld_attr;
          if (ld_prsv) m_base = m_vict + 1;
          m_vict = m_vict + 1;
          if (m_vict == N) m_vict = (m_base == N) ? 0 : m_base;
        end
      end else if (lock_we) begin
        m_base = (int'(lock_base_wr) > N) ? N : int'(lock_base_wr);
        m_vict = (int'(lock_vict_wr) > N - 1) ? N - 1 : int'(lock_vict_wr);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 lock_base", 64'(lock_base), 64'(m_base));
      chk("R4 lock_vict", 64'(lock_vict), 64'(m_vict));
      chk("R6 ld_err", 64'(ld_err), 64'(m_err));
      chk("R7 rd_valid", 64'(rd_valid), 64'(m_v[m_vict]));
      if (m_v[m_vict]) begin
        chk("R7 rd_tag", 64'(rd_tag), 64'(m_t[m_vict]));
        chk("R7 rd_pa", 64'(rd_pa), 64'(m_a[m_vict]));
        chk("R7 rd_size", 64'(rd_size), 64'(m_s[m_vict]));
        chk("R7 rd_prsv", 64'(rd_prsv), 64'(m_p[m_vict]));
      end
      chk("R3 lk_hit/miss", {62'd0, lk_hit, lk_miss}, {62'd0, m_hit, m_miss});
      chk("R2 lk_pa", 64'(lk_pa), 64'(m_lpa));
      chk("R2 lk_attr", 64'(lk_attr), 64'(m_lat));
    end
  end

  // ---------------- stimulus ----------------
  bit          got_err;
  logic        got_hit, got_miss;
  logic [31:0] got_pa;
  logic [3:0]  got_attr;

  task automatic op(bit fa, bit fl, logic [31:0] fad, bit ld, logic [31:0] tg, logic [1:0] sz,
                    bit pr, logic [31:0] pa, logic [3:0] at, bit lw, int b, int v);
    @(negedge clk);
    flush_all_stb = fa; flush_addr_stb = fl; flush_addr = fad;
    ld_stb = ld; ld_tag = tg; ld_size = sz; ld_prsv = pr; ld_pa = pa; ld_attr = at;
    lock_we = lw; lock_base_wr = BW'(b); lock_vict_wr = VW'(v);
    @(negedge clk);
    got_err = ld_err;
    flush_all_stb = 0; flush_addr_stb = 0; ld_stb = 0; lock_we = 0;
  endtask

  task automatic load(logic [31:0] tg, logic [1:0] sz, bit pr, logic [31:0] pa, logic [3:0] at);
    op(0, 0, 0, 1, tg, sz, pr, pa, at, 0, 0, 0);
  endtask

  task automatic setlock(int b, int v);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, b, v);
  endtask

  task automatic look(logic [31:0] a);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    got_hit = lk_hit; got_miss = lk_miss; got_pa = lk_pa; got_attr = lk_attr;
    lk_valid = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 base", 64'(lock_base), 0);
    chk("R1 vict", 64'(lock_vict), 0);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    chk("R1 lookup idle", {62'd0, lk_hit, lk_miss}, 0);
    look(32'h1000_0000);
    chk("R3 miss on empty", {62'd0, got_hit, got_miss}, 64'b01);

    // R5 preserved load at slot 0
    load(32'h1000_0000, 2'd0, 1, 32'h8000_0000, 4'd1);
    chk("R5 base after preserve", 64'(lock_base), 1);
    chk("R4 vict after load", 64'(lock_vict), 1);
    load(32'h2001_0000, 2'd1, 0, 32'h9004_0000, 4'd2);
    load(32'h3010_0000, 2'd2, 0, 32'hA020_0000, 4'd3);
    load(32'h4400_0000, 2'd3, 0, 32'hB500_0000, 4'd4);
    load(32'h1000_0000, 2'd3, 0, 32'hC000_0000, 4'd5);

    // R2 translation per page size
    look(32'h2001_3456); chk("R2 64K pa", 64'(got_pa), 64'h9004_3456);
    look(32'h301A_BCDE); chk("R2 1M pa", 64'(got_pa), 64'hA02A_BCDE);
    look(32'h4412_3456); chk("R2 16M pa", 64'(got_pa), 64'hB512_3456);
    chk("R2 16M attr", 64'(got_attr), 4);
    // R3 lowest index wins on overlap
    look(32'h1000_0ABC); chk("R3 lowest index pa", 64'(got_pa), 64'h8000_0ABC);
    chk("R3 lowest index attr", 64'(got_attr), 1);
    look(32'h10FF_F000); chk("R3 only large page", 64'(got_pa), 64'hC0FF_F000);
    look(32'h5000_0000); chk("R3 miss", {62'd0, got_hit, got_miss}, 64'b01);

    // R4 fill and wrap to base
    load(32'h6000_0000, 2'd0, 0, 32'h0000_1000, 4'd6);
    load(32'h6000_1000, 2'd0, 0, 32'h0000_2000, 4'd7);
    load(32'h6000_2000, 2'd0, 0, 32'h0000_3000, 4'd8);
    chk("R4 wrap to base", 64'(lock_vict), 1);
    load(32'h7000_0000, 2'd0, 0, 32'hD000_0000, 4'd9);
    look(32'h2001_3456); chk("R4 overwritten slot gone", {62'd0, got_hit, got_miss}, 64'b01);

    // R7 read back by victim index
    setlock(1, 4);
    chk("R7 read tag", 64'(rd_tag), 64'h1000_0000);
    chk("R7 read size", 64'(rd_size), 3);
    setlock(1, 0);
    chk("R7 read preserved", {62'd0, rd_valid, rd_prsv}, 64'b11);

    // R6 victim below base rejected
    load(32'hEEEE_0000, 2'd0, 0, 32'hEEEE_0000, 4'd15);
    chk("R6 err pulse", 64'(got_err), 1);
    chk("R6 slot untouched", 64'(rd_tag), 64'h1000_0000);
    @(negedge clk);
    chk("R6 err one cycle", 64'(ld_err), 0);

    // R10 clamp, then R6 full rejection
    setlock(15, 2);
    chk("R10 base clamp", 64'(lock_base), 8);
    load(32'hEEEE_0000, 2'd0, 0, 32'hEEEE_0000, 4'd15);
    chk("R6 full reject", 64'(got_err), 1);
    chk("R6 lock kept", 64'(lock_vict), 2);
    setlock(1, 2);

    // R8 flush by address
    op(0, 1, 32'h44AB_CDEF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(32'h4412_3456); chk("R8 covered entry gone", {62'd0, got_hit, got_miss}, 64'b01);
    look(32'h301A_BCDE); chk("R8 other entry kept", {62'd0, got_hit, got_miss}, 64'b10);
    op(0, 1, 32'h1000_0800, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(32'h1000_0ABC); chk("R8 overlap both gone", {62'd0, got_hit, got_miss}, 64'b01);
    chk("R8 lock unchanged", {32'(lock_base), 32'(lock_vict)}, {32'd1, 32'd2});

    // R11 priority
    op(0, 1, 32'h301A_BCDE, 1, 32'h7700_0000, 2'd0, 0, 32'h1, 4'd1, 0, 0, 0);
    chk("R11 load under flush ignored", 64'(lock_vict), 2);
    look(32'h7700_0000); chk("R11 no entry written", {62'd0, got_hit, got_miss}, 64'b01);
    op(0, 0, 0, 1, 32'h7700_0000, 2'd0, 0, 32'h1234_5000, 4'd3, 1, 6, 6);
    chk("R11 lock write ignored under load", {32'(lock_base), 32'(lock_vict)}, {32'd1, 32'd3});

    // R9 global flush wins over load
    op(1, 0, 0, 1, 32'h7800_0000, 2'd0, 1, 32'h1, 4'd1, 0, 0, 0);
    chk("R9 lock cleared", {32'(lock_base), 32'(lock_vict)}, 0);
    look(32'h7700_0000); chk("R9 all invalid", {62'd0, got_hit, got_miss}, 64'b01);
    look(32'h6000_0000); chk("R9 all invalid b", {62'd0, got_hit, got_miss}, 64'b01);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule